// File: doc/BRIEF.md
# Sequenced Serial Flash Cycle Engine

This block runs a complete serial flash operation from a short request. The request gives a cycle type (read, program or erase), a byte count, a 25-bit linear address and an erase granularity. Software never supplies flash opcodes. The engine expands the cycle type into the full command sequence on a four-wire SPI bus in mode 0. Program and erase cycles are preceded by a write-enable frame. After a program or erase, the engine polls the flash status register until the busy bit clears. At the end it raises a sticky done flag or a sticky error flag.

The engine checks every request before any bus activity. A request is rejected, with only the error flag raised and no frame sent, in these cases:
- a read or program that would run past a 256-byte page;
- an erase that is not aligned to its block size;
- an erase granularity that has no matching opcode;
- the reserved cycle code;
- an address beyond the 24-bit wire address.

A 64-byte buffer holds the data for both directions. The host fills it before a program cycle and reads it after a read cycle.

Top module: `hsf_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and busy, done and err are all 0.
- R2: A cycle code of 0 (read) sends one frame. The frame holds opcode 0x03, then addr[23:0] as three bytes with the most significant byte first, then cnt_m1+1 dummy bytes of 0x00. The byte received during dummy byte i is stored at buffer index i. Then done is set.
- R3: A cycle code of 2 (program) first sends a frame holding only 0x06. Next comes a frame with 0x02, the three address bytes, and buffer bytes 0 to cnt_m1. Next come status frames, each holding 0x05 and one dummy byte, until a returned status byte has bit 0 clear. Then done is set.
- R4: A cycle code of 3 (erase) uses the same write-enable and status-poll framing as R3. Its command frame holds the erase opcode and the three address bytes. The erase opcode is 0x20 when erase_sz is 1 (4 KiB) and 0xD8 when erase_sz is 3 (64 KiB).
- R5: A read or program with addr[7:0] + cnt_m1 > 255 sets err and sends no frame. A request that ends exactly on byte 255 of the page is accepted.
- R6: An erase is rejected (err set, no frame) in two cases: erase_sz is 0 (256 B) or 2 (8 KiB), which have no opcode; or the address is not a multiple of the block size.
- R7: A cycle code of 1, or any request with addr[24] set, sets err and sends no frame.
- R8: If POLL_LIMIT consecutive status bytes all report busy, the engine raises err instead of done and releases chip select.
- R9: done and err hold their value until clr_done or clr_err, respectively, is pulsed. Each clear affects only its own flag.
- R10: spi_sclk is high only while spi_cs_n is low, and each bit is shifted out most significant first. spi_cs_n returns high between frames.
- R11: A go pulse while busy is 1 is ignored and changes neither the frames sent nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only while idle |
| cyc | input | 2 | Cycle code: 0 read, 1 reserved, 2 program, 3 erase |
| cnt_m1 | input | 6 | Byte count minus one |
| addr | input | 25 | Linear flash address |
| erase_sz | input | 2 | Erase granularity: 0 256 B, 1 4 KiB, 2 8 KiB, 3 64 KiB |
| clr_done | input | 1 | Write-one clear of done |
| clr_err | input | 1 | Write-one clear of err |
| buf_we | input | 1 | Host buffer write strobe, dropped while busy |
| buf_widx | input | 6 | Host buffer write index |
| buf_wdata | input | 8 | Host buffer write data |
| buf_ridx | input | 6 | Host buffer read index |
| buf_rdata | output | 8 | Host buffer read data (combinational) |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Sticky cycle-complete flag |
| err | output | 1 | Sticky error flag |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench targets four groups of corner cases:
- page edges: a request ending on byte 255 must pass, and one ending on byte 256 must be stopped before chip select ever falls;
- erase inputs: a misaligned address and the two granularities that have no opcode must both be rejected;
- endless busy: a status that never clears must end in err after exactly POLL_LIMIT status frames;
- go while busy: a second go during a transfer must change nothing.

An engine that checked the page span off by one would either corrupt the next page or refuse a legal full-tail access. A poll counter off by one shows as one status frame too many or too few. An engine that latched a second go would show as an extra frame or a swapped opcode in the recorded bus log.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    localparam int SPI_AW = 24;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SE4K  = 8'h20;
    localparam logic [7:0] OP_BE64K = 8'hD8;

    typedef enum logic [1:0] {
        CYC_READ  = 2'd0,
        CYC_RSVD  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_ERASE = 2'd3
    } cyc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WREN,
        S_GAP,
        S_XFER,
        S_POLL,
        S_FIN
    } seq_state_e;

    typedef struct packed {
        logic       ok;
        logic       wren;
        logic       has_data;
        logic       rx_data;
        logic       poll;
        logic [7:0] opcode;
    } plan_t;

    function automatic int erase_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    return 8;
            2'd1:    return 12;
            2'd2:    return 13;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/hsf_buffer.sv
module hsf_buffer #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata_a = mem_q[ridx_a];
    assign rdata_b = mem_q[ridx_b];

endmodule

// File: rtl/hsf_check.sv
module hsf_check
    import hsf_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int CNT_W  = 6,
    parameter int PAGE_W = 8
) (
    input  cyc_e              cyc,
    input  logic [CNT_W-1:0]  cnt_m1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        erase_sz,
    output plan_t             plan
);

    logic [PAGE_W:0]     span_end;
    logic                crosses;
    logic                out_of_range;
    logic [SPI_AW-1:0]   low_mask;
    logic                misaligned;

    assign span_end     = {1'b0, addr[PAGE_W-1:0]} + (PAGE_W+1)'(cnt_m1);
    assign crosses      = span_end[PAGE_W];
    assign out_of_range = (addr >> SPI_AW) != '0;
    assign low_mask     = (SPI_AW'(1) << erase_bits(erase_sz)) - SPI_AW'(1);
    assign misaligned   = (addr[SPI_AW-1:0] & low_mask) != '0;

    always_comb begin
        plan = '0;
        case (cyc)
            CYC_READ: begin
                plan.ok       = !crosses && !out_of_range;
                plan.has_data = 1'b1;
                plan.rx_data  = 1'b1;
                plan.opcode   = OP_READ;
            end
            CYC_WRITE: begin
                plan.ok       = !crosses && !out_of_range;
                plan.wren     = 1'b1;
                plan.has_data = 1'b1;
                plan.poll     = 1'b1;
                plan.opcode   = OP_PROG;
            end
            CYC_ERASE: begin
                plan.wren   = 1'b1;
                plan.poll   = 1'b1;
                plan.opcode = (erase_sz == 2'd3) ? OP_BE64K : OP_SE4K;
                plan.ok     = !out_of_range && !misaligned &&
                              (erase_sz == 2'd1 || erase_sz == 2'd3);
            end
            default: plan = '0;
        endcase
    end

endmodule

// File: rtl/hsf_shifter.sv
module hsf_shifter #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] tx,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx
);

    logic          active_q;
    logic          phase_q;
    logic [W-1:0]  sh_q;
    logic [W-1:0]  rx_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            sh_q     <= '0;
            rx_q     <= '0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                sh_q     <= tx;
                active_q <= 1'b1;
                phase_q  <= 1'b0;
                cnt_q    <= CW'(W-1);
            end else if (active_q) begin
                if (!phase_q) begin
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    rx_q    <= {rx_q[W-2:0], miso};
                    sh_q    <= {sh_q[W-2:0], 1'b0};
                    if (cnt_q == '0) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
            end
        end
    end

    assign sclk = phase_q;
    assign mosi = sh_q[W-1];
    assign done = done_q;
    assign rx   = rx_q;

    AST_SHF_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !active_q); // R10
    AST_SHF_HALF_BIT: assert property (@(posedge clk) disable iff (rst)
        (active_q && phase_q) |=> !phase_q); // R10

endmodule

// File: rtl/hsf_engine.sv
module hsf_engine
    import hsf_pkg::*;
#(
    parameter int ADDR_W     = 25,
    parameter int DEPTH      = 64,
    parameter int PAGE_BYTES = 256,
    parameter int POLL_LIMIT = 64,
    localparam int CNT_W     = $clog2(DEPTH),
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int POS_W     = $clog2(DEPTH + 5),
    localparam int POLL_W    = $clog2(POLL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [1:0]        cyc,
    input  logic [CNT_W-1:0]  cnt_m1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        erase_sz,
    input  logic              clr_done,
    input  logic              clr_err,
    input  logic              buf_we,
    input  logic [CNT_W-1:0]  buf_widx,
    input  logic [7:0]        buf_wdata,
    input  logic [CNT_W-1:0]  buf_ridx,
    output logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    plan_t             req_plan;
    plan_t             plan_q;
    seq_state_e        st_q;
    seq_state_e        gap_to_q;
    logic [SPI_AW-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [POS_W-1:0]  pos_q;
    logic [POLL_W-1:0] poll_q;
    logic              cs_n_q;
    logic              start_q;
    logic [7:0]        tx_q;
    logic              done_q;
    logic              err_q;

    logic              shf_done;
    logic [7:0]        shf_rx;
    logic [POS_W-1:0]  next_pos;
    logic [POS_W-1:0]  last_pos;
    logic [7:0]        tx_next;
    logic [7:0]        eng_rdata;
    logic              eng_we;
    logic [CNT_W-1:0]  eng_widx;
    logic [CNT_W-1:0]  eng_ridx;
    logic              mem_we;
    logic [CNT_W-1:0]  mem_widx;
    logic [7:0]        mem_wdata;
    logic              accept;

    hsf_check #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PAGE_W (PAGE_W)
    ) u_check (
        .cyc      (cyc_e'(cyc)),
        .cnt_m1   (cnt_m1),
        .addr     (addr),
        .erase_sz (erase_sz),
        .plan     (req_plan)
    );

    hsf_shifter #(.W(8)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start_q),
        .tx    (tx_q),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (shf_done),
        .rx    (shf_rx)
    );

    assign next_pos = pos_q + POS_W'(1);
    assign last_pos = plan_q.has_data ? (POS_W'(4) + POS_W'(cnt_q)) : POS_W'(3);
    assign eng_ridx = CNT_W'(next_pos - POS_W'(4));
    assign eng_widx = CNT_W'(pos_q - POS_W'(4));
    assign eng_we   = (st_q == S_XFER) && shf_done && plan_q.rx_data &&
                      (pos_q >= POS_W'(4));

    always_comb begin
        case (next_pos)
            POS_W'(1): tx_next = addr_q[23:16];
            POS_W'(2): tx_next = addr_q[15:8];
            POS_W'(3): tx_next = addr_q[7:0];
            default:   tx_next = plan_q.rx_data ? 8'h00 : eng_rdata;
        endcase
    end

    assign mem_we    = busy ? eng_we   : buf_we;
    assign mem_widx  = busy ? eng_widx : buf_widx;
    assign mem_wdata = busy ? shf_rx   : buf_wdata;

    hsf_buffer #(.DEPTH(DEPTH), .DATA_W(8)) u_buf (
        .clk     (clk),
        .we      (mem_we),
        .widx    (mem_widx),
        .wdata   (mem_wdata),
        .ridx_a  (buf_ridx),
        .rdata_a (buf_rdata),
        .ridx_b  (eng_ridx),
        .rdata_b (eng_rdata)
    );

    assign busy   = (st_q != S_IDLE);
    assign accept = go && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            gap_to_q <= S_XFER;
            plan_q   <= '0;
            addr_q   <= '0;
            cnt_q    <= '0;
            pos_q    <= '0;
            poll_q   <= '0;
            cs_n_q   <= 1'b1;
            start_q  <= 1'b0;
            tx_q     <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (clr_done) done_q <= 1'b0;
            if (clr_err)  err_q  <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (accept) begin
                        if (!req_plan.ok) begin
                            err_q <= 1'b1;
                        end else begin
                            plan_q  <= req_plan;
                            addr_q  <= addr[SPI_AW-1:0];
                            cnt_q   <= cnt_m1;
                            pos_q   <= '0;
                            poll_q  <= '0;
                            cs_n_q  <= 1'b0;
                            start_q <= 1'b1;
                            if (req_plan.wren) begin
                                st_q <= S_WREN;
                                tx_q <= OP_WREN;
                            end else begin
                                st_q <= S_XFER;
                                tx_q <= req_plan.opcode;
                            end
                        end
                    end
                end
                S_WREN: begin
                    if (shf_done) begin
                        cs_n_q   <= 1'b1;
                        st_q     <= S_GAP;
                        gap_to_q <= S_XFER;
                    end
                end
                S_GAP: begin
                    cs_n_q  <= 1'b0;
                    start_q <= 1'b1;
                    pos_q   <= '0;
                    st_q    <= gap_to_q;
                    tx_q    <= (gap_to_q == S_XFER) ? plan_q.opcode : OP_RDSR;
                end
                S_XFER: begin
                    if (shf_done) begin
                        if (pos_q == last_pos) begin
                            cs_n_q <= 1'b1;
                            if (plan_q.poll) begin
                                st_q     <= S_GAP;
                                gap_to_q <= S_POLL;
                            end else begin
                                st_q <= S_FIN;
                            end
                        end else begin
                            pos_q   <= next_pos;
                            start_q <= 1'b1;
                            tx_q    <= tx_next;
                        end
                    end
                end
                S_POLL: begin
                    if (shf_done) begin
                        if (pos_q == '0) begin
                            pos_q   <= POS_W'(1);
                            start_q <= 1'b1;
                            tx_q    <= 8'h00;
                        end else begin
                            cs_n_q <= 1'b1;
                            if (!shf_rx[0]) begin
                                st_q <= S_FIN;
                            end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
                                err_q <= 1'b1;
                                st_q  <= S_IDLE;
                            end else begin
                                poll_q   <= poll_q + POLL_W'(1);
                                st_q     <= S_GAP;
                                gap_to_q <= S_POLL;
                            end
                        end
                    end
                end
                S_FIN: begin
                    done_q <= 1'b1;
                    st_q   <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign spi_cs_n = cs_n_q;
    assign done     = done_q;
    assign err      = err_q;

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n); // R10
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n); // R1
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_plan.ok) |=> (err && !busy && spi_cs_n)); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy); // R2
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        poll_q < POLL_W'(POLL_LIMIT)); // R8
    AST_GO_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (go && busy && st_q == S_XFER && !shf_done) |=> $stable(plan_q)); // R11

endmodule

// File: tb/test_hsf_engine.sv
module test_hsf_engine;

    localparam int POLL_N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [1:0]  cyc = '0;
    logic [5:0]  cnt_m1 = '0;
    logic [24:0] addr = '0;
    logic [1:0]  erase_sz = '0;
    logic        clr_done = 1'b0;
    logic        clr_err = 1'b0;
    logic        buf_we = 1'b0;
    logic [5:0]  buf_widx = '0;
    logic [7:0]  buf_wdata = '0;
    logic [5:0]  buf_ridx = '0;
    logic [7:0]  buf_rdata;
    logic        busy, done, err;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit in_req = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hsf_engine #(.POLL_LIMIT(POLL_N)) i_hsf_engine (
        .clk(clk), .rst(rst), .go(go), .cyc(cyc), .cnt_m1(cnt_m1),
        .addr(addr), .erase_sz(erase_sz), .clr_done(clr_done),
        .clr_err(clr_err), .buf_we(buf_we), .buf_widx(buf_widx),
        .buf_wdata(buf_wdata), .buf_ridx(buf_ridx), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .err(err), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- behavioural flash model ----------------
    logic [7:0] fl_bytes[$];
    int         fl_len[$];
    logic [7:0] exp_bytes[$];
    int         exp_len[$];
    int         cur_len;
    bit         open_f = 1'b0;
    int         nbits, fidx, faddr;
    logic [7:0] sh, op, resp;
    int         busy_left = 0;

    function automatic logic [7:0] fmem(input int a);
        return 8'(a * 13 + 7);
    endfunction

    always @(negedge spi_cs_n) begin
        nbits = 0; fidx = 0; faddr = 0; op = 8'h00; resp = 8'h00;
        spi_miso = 1'b0; open_f = 1'b1;
    end

    always @(posedge spi_cs_n) begin
        if (open_f) fl_len.push_back(fidx);
        open_f = 1'b0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            sh = {sh[6:0], spi_mosi};
            nbits++;
            if (nbits % 8 == 0) begin
                fl_bytes.push_back(sh);
                if (fidx == 0) op = sh;
                else if (fidx <= 3) faddr = (faddr << 8) | int'(sh);
                fidx++;
                resp = 8'h00;
                if (op == 8'h05 && fidx == 1) begin
                    resp = (busy_left > 0) ? 8'h01 : 8'h00;
                    if (busy_left > 0) busy_left--;
                end else if (op == 8'h03 && fidx >= 4) begin
                    resp = fmem(faddr + fidx - 4);
                end
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) spi_miso = resp[7 - (nbits % 8)];
    end

    // ---------------- per-clock reference comparison ----------------
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sclk && spi_cs_n) begin
                errors++;
                $display("FAIL R10 sclk high with cs_n high: actual 1 expected 0");
            end
            if (!in_req && (!spi_cs_n || busy || spi_sclk)) begin
                errors++;
                $display("FAIL R11 activity while idle: cs_n=%0b busy=%0b sclk=%0b expected 1/0/0",
                         spi_cs_n, busy, spi_sclk);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ef_begin(); cur_len = 0; endtask
    task automatic eb(input logic [7:0] b); exp_bytes.push_back(b); cur_len++; endtask
    task automatic ef_end(); exp_len.push_back(cur_len); endtask

    task automatic clear_logs();
        fl_bytes.delete(); fl_len.delete(); exp_bytes.delete(); exp_len.delete();
    endtask

    task automatic cmp_frames(input string tag);
        bit ok = (fl_len.size() == exp_len.size()) && (fl_bytes.size() == exp_bytes.size());
        if (ok) begin
            for (int i = 0; i < exp_len.size(); i++) if (fl_len[i] != exp_len[i]) ok = 0;
            for (int i = 0; i < exp_bytes.size(); i++) if (fl_bytes[i] != exp_bytes[i]) ok = 0;
        end
        chk(ok, {tag, " frames (count/bytes)"}, fl_bytes.size(), exp_bytes.size());
    endtask

    task automatic pulse_go(input logic [1:0] c, input logic [5:0] n,
                            input logic [24:0] a, input logic [1:0] es);
        @(negedge clk);
        go = 1'b1; cyc = c; cnt_m1 = n; addr = a; erase_sz = es;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_done = 1'b1; clr_err = 1'b1;
        @(negedge clk); clr_done = 1'b0; clr_err = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!(done || err) && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (40) @(negedge clk);
        in_req = 1'b0;
    endtask

    task automatic run(input logic [1:0] c, input logic [5:0] n,
                       input logic [24:0] a, input logic [1:0] es);
        clear_flags();
        in_req = 1'b1;
        pulse_go(c, n, a, es);
        wait_end();
    endtask

    task automatic exp_polls(input int count);
        for (int k = 0; k < count; k++) begin
            ef_begin(); eb(8'h05); eb(8'h00); ef_end();
        end
    endtask

    task automatic exp_addr(input int a);
        eb(8'(a >> 16)); eb(8'(a >> 8)); eb(8'(a));
    endtask

    task automatic fill_buf(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_widx = 6'(i); buf_wdata = 8'(8'hA0 + i);
        end
        @(negedge clk); buf_we = 1'b0;
    endtask

    task automatic check_read_buf(input int a, input int n, input string tag);
        bit ok = 1'b1;
        int bad_act = 0, bad_exp = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); buf_ridx = 6'(i);
            #1;
            if (buf_rdata != fmem(a + i)) begin
                ok = 0; bad_act = buf_rdata; bad_exp = fmem(a + i);
            end
        end
        chk(ok, tag, bad_act, bad_exp);
    endtask

    task automatic expect_flags(input bit d, input bit e, input string tag);
        chk(done == d && err == e, tag, {done, err}, {d, e});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n && !spi_sclk && !busy && !done && !err, "R1 reset outputs",
            {spi_cs_n, spi_sclk, busy, done, err}, 5'b10000);

        // R2 read of 4 bytes
        clear_logs();
        run(2'd0, 6'd3, 25'h012340, 2'd0);
        ef_begin(); eb(8'h03); exp_addr('h012340); for (int i = 0; i < 4; i++) eb(8'h00); ef_end();
        cmp_frames("R2 read4");
        expect_flags(1, 0, "R2 read4 flags");
        check_read_buf('h012340, 4, "R2 read4 buffer");

        // R2 read of full 64-byte span from page start
        clear_logs();
        run(2'd0, 6'd63, 25'h00AB00, 2'd0);
        ef_begin(); eb(8'h03); exp_addr('h00AB00); for (int i = 0; i < 64; i++) eb(8'h00); ef_end();
        cmp_frames("R2 read64");
        check_read_buf('h00AB00, 64, "R2 read64 buffer");

        // R5 one byte on last page byte is accepted
        clear_logs();
        run(2'd0, 6'd0, 25'h0000FF, 2'd0);
        ef_begin(); eb(8'h03); exp_addr('h0000FF); eb(8'h00); ef_end();
        cmp_frames("R5 exact page end");
        expect_flags(1, 0, "R5 exact page end flags");

        // R3 program 8 bytes, flash busy for 3 polls
        fill_buf(8);
        clear_logs();
        busy_left = 3;
        run(2'd2, 6'd7, 25'h000310, 2'd0);
        ef_begin(); eb(8'h06); ef_end();
        ef_begin(); eb(8'h02); exp_addr('h000310); for (int i = 0; i < 8; i++) eb(8'(8'hA0 + i)); ef_end();
        exp_polls(4);
        cmp_frames("R3 program8");
        expect_flags(1, 0, "R3 program8 flags");

        // R5 page crossing program rejected
        clear_logs();
        run(2'd2, 6'd7, 25'h0000F9, 2'd0);
        cmp_frames("R5 crossing program");
        expect_flags(0, 1, "R5 crossing flags");

        // R4 4 KiB erase
        clear_logs();
        busy_left = 2;
        run(2'd3, 6'd0, 25'h003000, 2'd1);
        ef_begin(); eb(8'h06); ef_end();
        ef_begin(); eb(8'h20); exp_addr('h003000); ef_end();
        exp_polls(3);
        cmp_frames("R4 erase4k");
        expect_flags(1, 0, "R4 erase4k flags");

        // R4 64 KiB erase
        clear_logs();
        busy_left = 0;
        run(2'd3, 6'd0, 25'h020000, 2'd3);
        ef_begin(); eb(8'h06); ef_end();
        ef_begin(); eb(8'hD8); exp_addr('h020000); ef_end();
        exp_polls(1);
        cmp_frames("R4 erase64k");

        // R6 misaligned erase and unsupported granularity
        clear_logs();
        run(2'd3, 6'd0, 25'h003100, 2'd1);
        cmp_frames("R6 misaligned erase");
        expect_flags(0, 1, "R6 misaligned flags");
        clear_logs();
        run(2'd3, 6'd0, 25'h000000, 2'd0);
        cmp_frames("R6 erase 256B size");
        expect_flags(0, 1, "R6 size flags");

        // R7 reserved code and high address bit
        clear_logs();
        run(2'd1, 6'd0, 25'h000000, 2'd0);
        cmp_frames("R7 reserved code");
        expect_flags(0, 1, "R7 reserved flags");
        clear_logs();
        run(2'd0, 6'd0, 25'h1000000, 2'd0);
        cmp_frames("R7 addr bit24");
        expect_flags(0, 1, "R7 addr flags");

        // R8 poll limit
        clear_logs();
        busy_left = 32'h7FFFFFFF;
        run(2'd2, 6'd0, 25'h000400, 2'd0);
        ef_begin(); eb(8'h06); ef_end();
        ef_begin(); eb(8'h02); exp_addr('h000400); eb(8'hA0); ef_end();
        exp_polls(POLL_N);
        cmp_frames("R8 poll timeout");
        expect_flags(0, 1, "R8 timeout flags");
        busy_left = 0;

        // R9 clears act on their own flag only
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
        expect_flags(0, 1, "R9 clr_done keeps err");
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        expect_flags(0, 0, "R9 clr_err clears err");

        // R11 second go while busy is ignored
        clear_logs();
        in_req = 1'b1;
        pulse_go(2'd0, 6'd3, 25'h000500, 2'd0);
        repeat (30) @(negedge clk);
        pulse_go(2'd3, 6'd0, 25'h000000, 2'd1);
        wait_end();
        ef_begin(); eb(8'h03); exp_addr('h000500); for (int i = 0; i < 4; i++) eb(8'h00); ef_end();
        cmp_frames("R11 go while busy");
        expect_flags(1, 0, "R11 flags");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule